// File: doc/BRIEF.md
# LIN Synchronization Field Duration Meter

This block times the synchronization byte of a LIN header with the local clock. The receiver first sees a break and pulses a strobe. The block then waits on the receive line for the first recessive-to-dominant transition of the 0x55 sync byte. From that transition it counts prescaled ticks of the local clock until the fifth such transition, which marks a span of eight bit times. Because the counter runs from the clock that is being trimmed, the count shows how far that clock is from nominal. A clock that runs fast gives a larger count and a slow clock gives a smaller one. For example, 20 MHz, 9600 baud and a divide-by-128 tick give a nominal count of 130. Trim logic elsewhere uses the result.

The receive line passes through an internal synchronizer. The tick divider is set at run time. A count that would go past its 8-bit ceiling aborts the measurement and raises a sticky error.

Top module: `lin_sync_meter`

## Requirements
- R1: After reset, `count_o` is 0, `valid_o` is 0 and `err_o` is 0. The internal view of the receive line starts recessive (1).
- R2: `rx_i` passes through two synchronizer flops and one history flop. A high-to-low change that is sampled at clock edge k is acted on at edge k+2. `valid_o` rises at the edge that acts on the fifth falling transition.
- R3: Falling transitions are counted only after a break strobe (`brk_i` high for a cycle). With no strobe since the last result or abort, edges on `rx_i` produce no result and no error.
- R4: With D = `presc_i` + 1, and L the number of clock cycles between the first and the fifth counted falling transitions of `rx_i`, the result is floor((L-1)/D). It is presented on `count_o`. `presc_i` must stay stable during a measurement.
- R5: `valid_o` is high for exactly one cycle per completed measurement. `count_o` changes only in that cycle and holds otherwise.
- R6: If L exceeds 256·D, the measurement aborts when the 256th tick is reached. `err_o` is set and no result is produced.
- R7: `err_o` stays high until the next break strobe, and the strobe clears it.
- R8: A break strobe during a measurement discards the partial count. The block re-arms and waits for a new first transition.
- R9: If the fifth transition is acted on in the same cycle as the tick that would overflow (L = 256·D), the result wins: `count_o` = 255 with `valid_o` and no error.
- R10: If a break strobe and a falling transition are acted on in the same cycle, the strobe wins. That transition is not counted as the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local clock, the one being measured |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Raw LIN receive line, 1 = recessive |
| brk_i | input | 1 | One-cycle strobe: break field detected |
| presc_i | input | 8 | Tick divider setting, divide ratio = value + 1 |
| count_o | output | 8 | Last measured sync span in ticks |
| valid_o | output | 1 | One-cycle pulse when `count_o` is updated |
| err_o | output | 1 | Sticky flag: the count ran past its ceiling |

## Verification
Two pairs of events can be acted on in the same cycle. The fifth falling transition can coincide with the overflowing tick, which the bench provokes with equal edge gaps whose total span is exactly 256 ticks. A break strobe can coincide with a falling transition, which the bench provokes by placing the strobe two cycles after a drop on `rx_i`. In the first case the bench expects a result of 255 with no error. In the second case it expects the coincident edge to be ignored, so the count comes only from the five edges that follow. A behavioural model predicts every output on every clock, and a span one tick longer is checked to produce the abort.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_MEAS  = 2'd2
    } meas_state_e;

endpackage

// File: rtl/lin_rx_sync.sv
// Synchronizes the receive line and flags a recessive-to-dominant change.
module lin_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rx_i,
    output logic fall_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    generate
        if (DEPTH > 1) begin : g_chain
            always_comb pipe_d = {pipe_q[DEPTH-2:0], rx_i};
        end else begin : g_single
            always_comb pipe_d = rx_i;
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= pipe_d;
    end

    // history flop high, newest synchronized sample low
    assign fall_o = pipe_q[DEPTH-1] & ~pipe_q[DEPTH-2];
endmodule

// File: rtl/lin_tick_div.sv
// Run-time programmable tick divider, ratio = div_i + 1.
module lin_tick_div #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] pre_d, pre_q;

    assign tick_o = en_i && (pre_q == div_i);

    always_comb begin
        pre_d = pre_q;
        if (clr_i)      pre_d = '0;
        else if (en_i)  pre_d = tick_o ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end
endmodule

// File: rtl/lin_sync_meter.sv
module lin_sync_meter
    import lin_sync_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 8,
    parameter int EDGES       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rx_i,
    input  logic             brk_i,
    input  logic [PRE_W-1:0] presc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             valid_o,
    output logic             err_o
);
    localparam int               EDGE_W  = $clog2(EDGES + 1);
    localparam logic [EDGE_W-1:0] LAST_E = EDGE_W'(EDGES - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;

    typedef struct packed {
        meas_state_e       state;
        logic [EDGE_W-1:0] edges;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  result;
        logic              valid;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;
    logic  fall, tick, start;

    lin_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rx_i   (rx_i),
        .fall_o (fall)
    );

    assign start = !brk_i && (r_q.state == ST_ARMED) && fall;

    lin_tick_div #(.W(PRE_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (start),
        .en_i   (r_q.state == ST_MEAS),
        .div_i  (presc_i),
        .tick_o (tick)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (brk_i) begin
            // break always re-arms, even over a coincident edge
            r_d.state = ST_ARMED;
            r_d.edges = '0;
            r_d.cnt   = '0;
            r_d.err   = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_ARMED: begin
                    if (fall) begin
                        r_d.state = ST_MEAS;
                        r_d.edges = EDGE_W'(1);
                        r_d.cnt   = '0;
                    end
                end
                ST_MEAS: begin
                    if (fall && r_q.edges == LAST_E) begin
                        // closing edge beats a simultaneous overflow tick
                        r_d.result = r_q.cnt;
                        r_d.valid  = 1'b1;
                        r_d.state  = ST_IDLE;
                    end else begin
                        if (fall) r_d.edges = r_q.edges + 1'b1;
                        if (tick) begin
                            if (r_q.cnt == CNT_MAX) begin
                                r_d.err   = 1'b1;
                                r_d.state = ST_IDLE;
                            end else begin
                                r_d.cnt = r_q.cnt + 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state  <= ST_IDLE;
            r_q.edges  <= '0;
            r_q.cnt    <= '0;
            r_q.result <= '0;
            r_q.valid  <= 1'b0;
            r_q.err    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign count_o = r_q.result;
    assign valid_o = r_q.valid;
    assign err_o   = r_q.err;
endmodule

// File: rtl/lin_sync_meter_chk.sv
module lin_sync_meter_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             brk_i,
    input logic [CNT_W-1:0] count_o,
    input logic             valid_o,
    input logic             err_o
);
    assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    assert_count_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(count_o) |-> valid_o);

    assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o && !brk_i) |=> err_o);

    assert_brk_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_i |=> (!err_o && !valid_o));

    assert_no_result_on_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> !err_o);
endmodule

bind lin_sync_meter lin_sync_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .brk_i   (brk_i),
    .count_o (count_o),
    .valid_o (valid_o),
    .err_o   (err_o)
);

// File: tb/sim_lin_sync_meter.sv
module sim_lin_sync_meter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       brk = 1'b0;
    logic [7:0] presc = 8'd0;
    logic [7:0] count;
    logic       valid, err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    lin_sync_meter u0 (
        .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .brk_i(brk),
        .presc_i(presc), .count_o(count), .valid_o(valid), .err_o(err)
    );

    // ---------------- behavioural reference ----------------
    bit  m1 = 1, m2 = 1, m3 = 1;
    int  mode = 0;            // 0 idle, 1 waiting first edge, 2 measuring
    int  nedge = 0, t0 = 0;
    int  e_count = 0;
    bit  e_valid = 0, e_err = 0;

    always @(posedge clk) begin
        bit fall;
        int d;
        cyc++;
        fall = m3 && !m2;
        d    = int'(presc) + 1;
        e_valid = 0;
        if (!rst_n) begin
            mode = 0; e_count = 0; e_err = 0;
            m1 = 1; m2 = 1; m3 = 1;
        end else begin
            if (brk) begin
                mode = 1; e_err = 0;
            end else if (mode == 1) begin
                if (fall) begin mode = 2; nedge = 1; t0 = cyc; end
            end else if (mode == 2) begin
                if (fall && nedge == 4) begin
                    e_count = (cyc - t0 - 1) / d;
                    e_valid = 1; mode = 0;
                end else begin
                    if (fall) nedge++;
                    if (cyc - t0 == 256 * d) begin e_err = 1; mode = 0; end
                end
            end
            m3 = m2; m2 = m1; m1 = rx;
        end
    end

    // per-clock comparison and result capture
    int n_valid = 0;
    int last_count = -1;
    always @(negedge clk) begin
        checks++;
        if (valid !== e_valid) begin
            fails++;
            $display("FAIL R2 valid timing: actual %0b expected %0b (cycle %0d)", valid, e_valid, cyc);
        end
        if (int'(count) !== e_count) begin
            fails++;
            $display("FAIL R4 count: actual %0d expected %0d (cycle %0d)", count, e_count, cyc);
        end
        if (err !== e_err) begin
            fails++;
            $display("FAIL R6 err: actual %0b expected %0b (cycle %0d)", err, e_err, cyc);
        end
        if (valid === 1'b1) begin n_valid++; last_count = int'(count); end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_brk();
        brk = 1'b1; @(negedge clk); brk = 1'b0;
    endtask

    // start bit, 0x55 LSB first, stop bit; p cycles per bit
    task automatic send_sync(int p);
        bit bits[10] = '{0, 1, 0, 1, 0, 1, 0, 1, 0, 1};
        foreach (bits[i]) begin
            rx = bits[i];
            wait_n(p);
        end
    endtask

    // five one-cycle dips spaced g cycles apart
    task automatic dips(int g);
        for (int i = 0; i < 5; i++) begin
            rx = 1'b0; @(negedge clk); rx = 1'b1;
            wait_n(g - 1);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
        finish_run();
    end

    initial begin
        wait_n(3);
        // R1: reset values
        check("R1 count", int'(count), 0);
        check("R1 valid", int'(valid), 0);
        check("R1 err",   int'(err),   0);
        rst_n = 1'b1;
        wait_n(3);

        // R3: edges without any break produce nothing
        send_sync(10); wait_n(10);
        check("R3 no result", n_valid, 0);
        check("R3 no error", int'(err), 0);

        // R4: divide by 1, 10 cycles per bit -> L=80 -> 79
        strobe_brk(); wait_n(4); send_sync(10); wait_n(6);
        check("R4 count d1", last_count, 79);
        check("R5 single pulse", n_valid, 1);

        // R4: divide by 4, 20 cycles per bit -> L=160 -> 39
        presc = 8'd3;
        strobe_brk(); wait_n(4); send_sync(20); wait_n(6);
        check("R4 count d4", last_count, 39);
        check("R5 single pulse", n_valid, 2);

        // R9: L = 256*D with D=1 -> 255, no error
        presc = 8'd0;
        strobe_brk(); wait_n(3); dips(64); wait_n(6);
        check("R9 boundary count", last_count, 255);
        check("R9 no error", int'(err), 0);

        // R9: L = 256*D with D=2 -> 255
        presc = 8'd1;
        strobe_brk(); wait_n(3); dips(128); wait_n(6);
        check("R9 boundary d2", last_count, 255);

        // R6: one step past the ceiling aborts
        presc = 8'd0;
        strobe_brk(); wait_n(3); dips(65); wait_n(6);
        check("R6 abort flag", int'(err), 1);
        check("R6 no result", n_valid, 4);
        check("R5 count held", int'(count), 255);

        // R7: error persists, break clears it
        wait_n(30);
        check("R7 sticky", int'(err), 1);
        strobe_brk();
        check("R7 cleared", int'(err), 0);

        // R8: break mid-measurement restarts; D=2, 8 cycles/bit -> 31
        presc = 8'd1;
        wait_n(3);
        rx = 1'b0; wait_n(8); rx = 1'b1; wait_n(8); rx = 1'b0; wait_n(8); rx = 1'b1;
        wait_n(3);
        strobe_brk(); wait_n(3); send_sync(8); wait_n(6);
        check("R8 restarted count", last_count, 31);

        // R10: break coincides with an acted-on fall; that fall is ignored
        presc = 8'd0;
        rx = 1'b0; @(negedge clk); @(negedge clk);
        brk = 1'b1; @(negedge clk); brk = 1'b0; rx = 1'b1;
        wait_n(3);
        dips(6); wait_n(6);
        check("R10 break wins", last_count, 23);
        check("R5 pulses total", n_valid, 6);

        wait_n(5);
        finish_run();
    end
endmodule